// File: doc/BRIEF.md
# JESD204B Transmitter Test-Mode Sequencer

This block chooses, one character slot at a time, what a JESD204B link-layer transmitter places on its lanes. It produces a stream of octets, each with a control-character flag and a phase code, which feed an 8b/10b encoder that sits outside the block. A two-bit mode input picks one of four behaviours. The first is the normal link: code group synchronization (CGS), then the initial lane alignment sequence (ILAS), then user data. The second is a repeated-alignment link, which runs the same synchronization flow but replays the ILAS without end and never reaches the data phase. The other two are fixed test streams, one of D21.5 data characters and one of K28.5 control characters.

The receiver's synchronization request (active low) and a multiframe boundary strobe steer the link modes. The strobe marks the character slot that opens a new multiframe. An internal position counter, sized by the multiframe length parameter, finds the last slot of each multiframe. Every output is registered: the character produced at a clock edge reflects the inputs sampled at that same edge. Codes used: K28.5 = 0xBC, D21.5 = 0xB5, K28.0 = 0x1C, K28.3 = 0x7C, K28.4 = 0x9C.

Top module: `jesd_test_mode_seq`

## Requirements
- R1: While reset is held, and at the first edge after it, the outputs are data 0xBC, K-flag 1, phase 0 (CGS), and the active mode is normal.
- R2: The mode select (0 normal, 1 repeated alignment, 2 D21.5, 3 K28.5) takes effect only in a slot where the multiframe strobe is high. A change at any other slot leaves the output stream unchanged until the next boundary.
- R3: In D21.5 mode every slot carries data 0xB5 with K-flag 0 and phase 3, whatever the sync request does.
- R4: In K28.5 mode every slot carries 0xBC with K-flag 1 and phase 3, whatever the sync request does. In the CGS phase (phase 0) every slot is also 0xBC with K-flag 1.
- R5: In either link mode, sync low sampled at a clock edge makes that edge's character 0xBC in phase 0, whatever phase came before.
- R6: The CGS phase ends only at a boundary slot sampled with sync high. That slot carries 0x1C (K-flag 1) in phase 1 (ILAS).
- R7: Within an ILAS multiframe, slot 0 is 0x1C and the last slot is 0x7C, both with K-flag 1. Slot 1 of the second multiframe (index 1) is 0x9C with K-flag 1. Every other slot carries its position in the multiframe as data with K-flag 0.
- R8: In normal mode, the boundary that follows the fourth ILAS multiframe starts the data phase (phase 2). From then on each slot carries the user data input with K-flag 0.
- R9: In repeated-alignment mode, the boundary after the fourth ILAS multiframe restarts the ILAS at multiframe 0, and the data phase is never entered.
- R10: A boundary that switches the mode into a link mode emits CGS (0xBC, phase 0) in that slot, even with sync high. The ILAS can start no earlier than the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Test-mode select: 0 normal, 1 repeated alignment, 2 D21.5, 3 K28.5 |
| syncN | input | 1 | Receiver synchronization request, active low |
| mfStrobe | input | 1 | High in the slot that opens a multiframe |
| userData | input | 8 | Data octet sent in the data phase |
| txData | output | 8 | Character octet for the encoder |
| txIsK | output | 1 | Marks txData as a control character |
| txPhase | output | 2 | 0 CGS, 1 ILAS, 2 data, 3 fixed test stream |

## Verification
The bench lifts sync in the middle of a multiframe. A design that left CGS on release, instead of at the boundary, would put 0x1C in a non-zero slot. It changes the mode mid-multiframe, where a design that acted at once would cut an ILAS multiframe short. It also switches into a link mode at a boundary with sync already high, where a design that skipped the restart would go straight to ILAS. Over two full repeated-alignment loops, a design that counted multiframes wrongly would enter the data phase or misplace the 0x9C marker. Sync pulses of one character, sent during the ILAS and during the data phase, catch a design that ignores short requests. Sync pulses sent in the fixed test modes catch a design that lets them disturb the stream.

// File: rtl/jesd_tm_pkg.sv
package jesd_tm_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_RILA   = 2'd1,
    MODE_D215   = 2'd2,
    MODE_K285   = 2'd3
  } tmMode_e;

  typedef enum logic [1:0] {
    PH_CGS  = 2'd0,
    PH_ILAS = 2'd1,
    PH_DATA = 2'd2,
    PH_TEST = 2'd3
  } linkPhase_e;

  typedef enum logic [2:0] {
    SEL_COMMA,
    SEL_ALT,
    SEL_MF_START,
    SEL_MF_END,
    SEL_CFG_MARK,
    SEL_INDEX,
    SEL_USER
  } charSel_e;

  localparam logic [7:0] CH_K285 = 8'hBC;
  localparam logic [7:0] CH_D215 = 8'hB5;
  localparam logic [7:0] CH_K280 = 8'h1C;
  localparam logic [7:0] CH_K283 = 8'h7C;
  localparam logic [7:0] CH_K284 = 8'h9C;

  localparam int ILAS_MF_COUNT = 4;
  localparam int CFG_MF_INDEX  = 1;

  // Strobes from control to datapath for one character slot
  typedef struct packed {
    charSel_e   sel;
    linkPhase_e phase;
    logic [7:0] index;
  } charCtrl_t;

endpackage

// File: rtl/jesd_tm_ctrl.sv
module jesd_tm_ctrl
  import jesd_tm_pkg::*;
#(
  parameter int MF_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       syncN,
  input  logic       mfStrobe,
  output charCtrl_t  slotCtrl
);

  localparam int POS_W    = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam int MF_CNT_W = $clog2(ILAS_MF_COUNT);
  localparam logic [POS_W-1:0]    LAST_POS = POS_W'(MF_LEN - 1);
  localparam logic [MF_CNT_W-1:0] LAST_MF  = MF_CNT_W'(ILAS_MF_COUNT - 1);
  localparam logic [MF_CNT_W-1:0] CFG_MF   = MF_CNT_W'(CFG_MF_INDEX);

  tmMode_e             modeQ, modeNext;
  linkPhase_e          phaseQ, phaseNext;
  logic [MF_CNT_W-1:0] mfQ, mfNext;
  logic [POS_W-1:0]    posQ, curPos;
  logic                isFirst, isLast, modeChange;
  charSel_e            selNext;

  // Slot position and effective mode
  always_comb begin
    if (mfStrobe || posQ == LAST_POS) curPos = '0;
    else                              curPos = posQ + 1'b1;
    isFirst    = (curPos == '0);
    isLast     = (curPos == LAST_POS);
    modeNext   = mfStrobe ? tmMode_e'(modeSel) : modeQ;
    modeChange = mfStrobe && (modeNext != modeQ);
  end

  // Phase sequencing
  always_comb begin
    phaseNext = phaseQ;
    mfNext    = mfQ;
    if (modeNext == MODE_D215 || modeNext == MODE_K285) begin
      phaseNext = PH_TEST;
      mfNext    = '0;
    end else if (!syncN || modeChange || phaseQ == PH_TEST) begin
      phaseNext = PH_CGS;
      mfNext    = '0;
    end else begin
      case (phaseQ)
        PH_CGS: begin
          if (mfStrobe) begin
            phaseNext = PH_ILAS;
            mfNext    = '0;
          end
        end
        PH_ILAS: begin
          if (mfStrobe) begin
            if (mfQ == LAST_MF) begin
              mfNext = '0;
              if (modeNext == MODE_NORMAL) phaseNext = PH_DATA;
            end else begin
              mfNext = mfQ + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Character choice for this slot
  always_comb begin
    case (phaseNext)
      PH_TEST: selNext = (modeNext == MODE_D215) ? SEL_ALT : SEL_COMMA;
      PH_ILAS: begin
        if (isFirst)                                        selNext = SEL_MF_START;
        else if (isLast)                                    selNext = SEL_MF_END;
        else if (mfNext == CFG_MF && curPos == POS_W'(1))   selNext = SEL_CFG_MARK;
        else                                                selNext = SEL_INDEX;
      end
      PH_DATA: selNext = SEL_USER;
      default: selNext = SEL_COMMA;
    endcase
    slotCtrl.sel   = selNext;
    slotCtrl.phase = phaseNext;
    slotCtrl.index = 8'(curPos);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_NORMAL;
      phaseQ <= PH_CGS;
      mfQ    <= '0;
      posQ   <= LAST_POS;
    end else begin
      modeQ  <= modeNext;
      phaseQ <= phaseNext;
      mfQ    <= mfNext;
      posQ   <= curPos;
    end
  end

endmodule

// File: rtl/jesd_tm_datapath.sv
module jesd_tm_datapath
  import jesd_tm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  charCtrl_t  slotCtrl,
  input  logic [7:0] userData,
  output logic [7:0] txData,
  output logic       txIsK,
  output logic [1:0] txPhase
);

  logic [7:0] charNext;
  logic       kNext;

  always_comb begin
    case (slotCtrl.sel)
      SEL_ALT:      begin charNext = CH_D215;        kNext = 1'b0; end
      SEL_MF_START: begin charNext = CH_K280;        kNext = 1'b1; end
      SEL_MF_END:   begin charNext = CH_K283;        kNext = 1'b1; end
      SEL_CFG_MARK: begin charNext = CH_K284;        kNext = 1'b1; end
      SEL_INDEX:    begin charNext = slotCtrl.index; kNext = 1'b0; end
      SEL_USER:     begin charNext = userData;       kNext = 1'b0; end
      default:      begin charNext = CH_K285;        kNext = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData  <= CH_K285;
      txIsK   <= 1'b1;
      txPhase <= PH_CGS;
    end else begin
      txData  <= charNext;
      txIsK   <= kNext;
      txPhase <= slotCtrl.phase;
    end
  end

endmodule

// File: rtl/jesd_test_mode_seq.sv
module jesd_test_mode_seq
  import jesd_tm_pkg::*;
#(
  parameter int MF_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       syncN,
  input  logic       mfStrobe,
  input  logic [7:0] userData,
  output logic [7:0] txData,
  output logic       txIsK,
  output logic [1:0] txPhase
);

  charCtrl_t slotCtrl;

  jesd_tm_ctrl #(.MF_LEN(MF_LEN)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .syncN    (syncN),
    .mfStrobe (mfStrobe),
    .slotCtrl (slotCtrl)
  );

  jesd_tm_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .slotCtrl (slotCtrl),
    .userData (userData),
    .txData   (txData),
    .txIsK    (txIsK),
    .txPhase  (txPhase)
  );

endmodule

// File: rtl/jesd_tm_seq_checker.sv
module jesd_tm_seq_checker
  import jesd_tm_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       syncN,
  input logic       mfStrobe,
  input logic [7:0] txData,
  input logic       txIsK,
  input logic [1:0] txPhase
);

  // R4
  cgs_comma_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase == PH_CGS) |-> (txIsK && txData == CH_K285));

  // R3
  alt_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase == PH_TEST && !txIsK) |-> (txData == CH_D215));

  // R4
  comma_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase == PH_TEST && txIsK) |-> (txData == CH_K285));

  // R5
  sync_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!syncN) |=> (txPhase == PH_CGS || txPhase == PH_TEST));

  // R2
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mfStrobe) |=> ((txPhase == PH_TEST) == ($past(txPhase) == PH_TEST)));

  // R6
  ilas_entry_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mfStrobe && txPhase != PH_ILAS) |=> (txPhase != PH_ILAS));

  // R6
  ilas_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase == PH_ILAS && $past(txPhase) != PH_ILAS) |-> (txIsK && txData == CH_K280));

  // R8
  data_not_control_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase == PH_DATA) |-> !txIsK);

  // R8
  no_data_after_cgs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPhase == PH_CGS) |=> (txPhase != PH_DATA));

  // R9
  rila_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mfStrobe && modeSel == MODE_RILA && txPhase != PH_DATA) |=> (txPhase != PH_DATA));

endmodule

bind jesd_test_mode_seq jesd_tm_seq_checker i_seq_checker (
  .clk      (clk),
  .rstN     (rstN),
  .modeSel  (modeSel),
  .syncN    (syncN),
  .mfStrobe (mfStrobe),
  .txData   (txData),
  .txIsK    (txIsK),
  .txPhase  (txPhase)
);

// File: tb/test_jesd_test_mode_seq.sv
module test_jesd_test_mode_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MF = 8;

  localparam logic [1:0] PC_CGS = 2'd0, PC_ILAS = 2'd1, PC_DATA = 2'd2, PC_TEST = 2'd3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       syncN = 1'b0;
  logic       mfStrobe = 1'b0;
  logic [7:0] userData = 8'h00;
  logic [7:0] txData;
  logic       txIsK;
  logic [1:0] txPhase;

  int checks = 0;
  int failures = 0;
  int slot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jesd_test_mode_seq #(.MF_LEN(MF)) i_jesd_test_mode_seq (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .syncN    (syncN),
    .mfStrobe (mfStrobe),
    .userData (userData),
    .txData   (txData),
    .txIsK    (txIsK),
    .txPhase  (txPhase)
  );

  task automatic check(input string req, input logic [7:0] expData,
                       input logic expK, input logic [1:0] expPhase);
    checks++;
    if (txData !== expData || txIsK !== expK || txPhase !== expPhase) begin
      failures++;
      $display("FAIL %s slot=%0d: data=%h k=%b phase=%0d expected data=%h k=%b phase=%0d",
               req, slot, txData, txIsK, txPhase, expData, expK, expPhase);
    end
  endtask

  // One character slot; the strobe marks every MF-th slot
  task automatic step();
    mfStrobe = (slot % MF == 0);
    @(posedge clk);
    #1;
    slot++;
  endtask

  task automatic ilasExpect(input int m, input int p,
                            output logic [7:0] d, output logic k);
    if (p == 0)               begin d = 8'h1C; k = 1'b1; end
    else if (p == MF - 1)     begin d = 8'h7C; k = 1'b1; end
    else if (m == 1 && p == 1) begin d = 8'h9C; k = 1'b1; end
    else                      begin d = 8'(p); k = 1'b0; end
  endtask

  task automatic runIlas(input string req, input int m, input int pFrom, input int pTo);
    logic [7:0] d;
    logic       k;
    for (int p = pFrom; p <= pTo; p++) begin
      step();
      ilasExpect(m, p, d, k);
      check(req, d, k, PC_ILAS);
    end
  endtask

  task automatic cgsToBoundary(input string req);
    while (slot % MF != 0) begin
      step();
      check(req, 8'hBC, 1'b1, PC_CGS);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", 8'hBC, 1'b1, PC_CGS);
    rstN = 1'b1;
    slot = 0;
  endtask

  task automatic testNormalLink();
    syncN = 1'b0;
    modeSel = 2'd0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(i == 0 ? "R1 first slot" : "R5 sync held", 8'hBC, 1'b1, PC_CGS);
    end
    syncN = 1'b1;
    cgsToBoundary("R6 waits for boundary");
    for (int m = 0; m < 4; m++) runIlas("R7 ilas", m, 0, MF - 1);
    for (int i = 0; i < 4; i++) begin
      userData = 8'hA0 + 8'(i);
      step();
      check("R8 data phase", 8'hA0 + 8'(i), 1'b0, PC_DATA);
    end
    syncN = 1'b0;
    step();
    check("R5 resync from data", 8'hBC, 1'b1, PC_CGS);
    syncN = 1'b1;
    cgsToBoundary("R6 cgs hold");
  endtask

  task automatic testRepeatedIla();
    modeSel = 2'd1;
    step();
    check("R10 restart on mode change", 8'hBC, 1'b1, PC_CGS);
    cgsToBoundary("R10 cgs before ilas");
    for (int m = 0; m < 8; m++) runIlas("R9 loop", m % 4, 0, MF - 1);
    runIlas("R9 loop", 0, 0, 2);
    syncN = 1'b0;
    step();
    check("R5 resync in ilas", 8'hBC, 1'b1, PC_CGS);
    syncN = 1'b1;
    cgsToBoundary("R6 cgs hold");
    runIlas("R6 ilas start", 0, 0, 2);
    modeSel = 2'd2;
    runIlas("R2 change deferred", 0, 3, MF - 1);
  endtask

  task automatic testFixedModes();
    for (int i = 0; i < MF + 2; i++) begin
      syncN = (i % 3 != 1);
      step();
      check("R3 d21.5 stream", 8'hB5, 1'b0, PC_TEST);
    end
    syncN = 1'b1;
    modeSel = 2'd3;
    while (slot % MF != 0) begin
      step();
      check("R2 deferred to boundary", 8'hB5, 1'b0, PC_TEST);
    end
    for (int i = 0; i < MF + 2; i++) begin
      syncN = (i % 2 == 0);
      step();
      check("R4 k28.5 stream", 8'hBC, 1'b1, PC_TEST);
    end
    syncN = 1'b1;
    while (slot % MF != 0) begin
      step();
      check("R4 k28.5 hold", 8'hBC, 1'b1, PC_TEST);
    end
    modeSel = 2'd0;
    step();
    check("R10 back to link", 8'hBC, 1'b1, PC_CGS);
    cgsToBoundary("R10 cgs hold");
    runIlas("R6 ilas after test mode", 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testNormalLink();
    testRepeatedIla();
    testFixedModes();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule